// File: doc/BRIEF.md
# PN9 Payload Whitener

This block scrambles or descrambles the payload of frames that move through a byte-wide valid/ready stream. Each byte is XORed with bits from a nine-stage pseudo-noise generator. The first bytes of every frame form a header, and these pass through untouched. The generator is loaded with a fixed nonzero seed on every start-of-frame beat. A per-frame enable, taken from the header decode upstream, chooses whether the payload of that frame is whitened at all.

Whitening and dewhitening are the same XOR operation. The same instance therefore sits in the transmit path before serialisation and in the receive path after byte assembly. The datapath is combinational from input to output. Only the generator state, the header position and the latched enable are registered, and they change only on an accepted beat.

Top module: `pn9_whitener`

## Requirements
- R1: `out_valid`, `out_sof` and `out_eof` follow `in_valid`, `in_sof` and `in_eof`, and `in_ready` follows `out_ready`, in the same cycle. A beat is accepted when `in_valid` and `out_ready` are both high.
- R2: The header passes with `out_data == in_data`. The header is the accepted beat with `in_sof` high plus the next `HDR_BYTES-1` accepted beats, and `HDR_BYTES` defaults to 2.
- R3: When the frame enable is high, each payload byte leaves as `in_data ^ mask`. Bit i of the mask (bit 0 first) is bit 0 of the generator state after i advances. One advance maps state s to `{s[0]^s[5], s[8:1]}`, which is the polynomial x^9+x^5+1. Each payload byte takes 8 advances, and consecutive payload bytes continue the sequence.
- R4: Every accepted start-of-frame beat loads the generator with 9'h1F0. The first payload byte of an enabled frame is therefore XORed with 8'hF0.
- R5: When the frame enable is low, payload bytes pass unchanged.
- R6: `in_wht_en` is sampled only on the accepted start-of-frame beat. Its value on later beats of that frame has no effect on the output.
- R7: Without an accepted beat (`in_valid` low or `out_ready` low), the generator and the header position hold. The next accepted payload byte uses the next mask in the sequence, and a stalled beat shows the same output on every cycle of the stall.
- R8: After reset and before the first start-of-frame, all bytes pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream may advance |
| in_data | input | 8 | Upstream byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_wht_en | input | 1 | Whitening enable for the frame, sampled at start-of-frame |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 8 | Whitened or passed byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |

## Verification
Every output depends combinationally on the beat presented in the same cycle. The bench therefore drives each beat just after a falling edge and samples one time unit later, before the rising edge that accepts it. A state update (reseed, header count, generator advance) shows up only on the beat presented after that rising edge. The bench advances its own model of the generator only when it drives a beat with both valid and ready high. During a stall it expects exactly the mask it had already predicted for that beat.

// File: rtl/pn9_whiten_pkg.sv
package pn9_whiten_pkg;

    localparam int BYTE_W   = 8;
    localparam int LFSR_W   = 9;
    localparam int TAP_OUT  = 0;
    localparam int TAP_FB   = 5;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LFSR_W-1:0] lfsr_t;

    localparam lfsr_t PN9_SEED = 9'h1F0;

    typedef enum logic [1:0] {
        BEAT_HDR    = 2'd0,
        BEAT_CLEAR  = 2'd1,
        BEAT_WHITEN = 2'd2
    } beat_kind_t;

    typedef struct packed {
        logic  sof;
        logic  eof;
        byte_t data;
    } beat_t;

    typedef struct packed {
        byte_t mask;
        lfsr_t next;
    } pn_step_t;

    function automatic lfsr_t pn9_advance(input lfsr_t s);
        return {s[TAP_OUT] ^ s[TAP_FB], s[LFSR_W-1:1]};
    endfunction

    function automatic pn_step_t pn9_byte_step(input lfsr_t s);
        pn_step_t r;
        lfsr_t    st;
        st = s;
        r.mask = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            r.mask[i] = st[TAP_OUT];
            st = pn9_advance(st);
        end
        r.next = st;
        return r;
    endfunction

endpackage

// File: rtl/pn9_lfsr_unit.sv
module pn9_lfsr_unit
    import pn9_whiten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  reseed,
    input  logic  advance,
    output byte_t mask
);

    lfsr_t    state_q;
    pn_step_t step;

    always_comb step = pn9_byte_step(state_q);

    assign mask = step.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PN9_SEED;
        end else if (reseed) begin
            state_q <= PN9_SEED;
        end else if (advance) begin
            state_q <= step.next;
        end
    end

endmodule

// File: rtl/pn9_frame_track.sv
module pn9_frame_track
    import pn9_whiten_pkg::*;
#(
    parameter int HDR_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       sof,
    input  logic       en_req,
    output beat_kind_t kind
);

    localparam int CNT_W = $clog2(HDR_BYTES + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] hdr_cnt_q;
    logic             en_q;
    logic             in_hdr;

    assign in_hdr = sof || (hdr_cnt_q < HDR_LAST);

    always_comb begin
        if (in_hdr) begin
            kind = BEAT_HDR;
        end else if (en_q) begin
            kind = BEAT_WHITEN;
        end else begin
            kind = BEAT_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_cnt_q <= HDR_LAST;
            en_q      <= 1'b0;
        end else if (fire) begin
            if (sof) begin
                hdr_cnt_q <= CNT_ONE;
                en_q      <= en_req;
            end else if (hdr_cnt_q < HDR_LAST) begin
                hdr_cnt_q <= hdr_cnt_q + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/pn9_whitener.sv
module pn9_whitener
    import pn9_whiten_pkg::*;
#(
    parameter int HDR_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_wht_en,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof
);

    beat_t      beat_in;
    beat_t      beat_out;
    beat_kind_t kind;
    byte_t      mask;
    logic       fire;

    assign beat_in  = '{sof: in_sof, eof: in_eof, data: in_data};
    assign fire     = in_valid && out_ready;

    pn9_frame_track #(
        .HDR_BYTES (HDR_BYTES)
    ) u_track (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .sof    (in_sof),
        .en_req (in_wht_en),
        .kind   (kind)
    );

    pn9_lfsr_unit u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .reseed  (fire && in_sof),
        .advance (fire && (kind == BEAT_WHITEN)),
        .mask    (mask)
    );

    always_comb begin
        beat_out = beat_in;
        if (kind == BEAT_WHITEN) begin
            beat_out.data = beat_in.data ^ mask;
        end
    end

    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = beat_out.data;
    assign out_sof   = beat_out.sof;
    assign out_eof   = beat_out.eof;

endmodule

// File: rtl/pn9_whitener_chk.sv
module pn9_whitener_chk #(
    parameter int HDR_BYTES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_sof,
    input logic       in_wht_en,
    input logic       out_ready,
    input logic [7:0] out_data
);

    localparam int CW = $clog2(HDR_BYTES + 1);
    localparam logic [CW-1:0] HL = CW'(HDR_BYTES);

    logic [CW-1:0] cnt_q;
    logic          en_q;
    logic          first_q;
    logic          hdr_now;
    logic          acc;

    assign acc     = in_valid && out_ready;
    assign hdr_now = in_sof || (cnt_q < HL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= HL;
            en_q    <= 1'b0;
            first_q <= 1'b0;
        end else if (acc) begin
            if (in_sof) begin
                cnt_q   <= CW'(1);
                en_q    <= in_wht_en;
                first_q <= 1'b1;
            end else if (cnt_q < HL) begin
                cnt_q <= cnt_q + CW'(1);
            end else begin
                first_q <= 1'b0;
            end
        end
    end

    AST_HDR_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hdr_now) |-> (out_data == in_data)); // R2

    AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hdr_now && !en_q) |-> (out_data == in_data)); // R5

    AST_FIRST_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hdr_now && en_q && first_q) |-> (out_data == (in_data ^ 8'hF0))); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(in_valid && !out_ready) && $stable(in_data) && $stable(in_sof))
        |-> $stable(out_data)); // R7

endmodule

bind pn9_whitener pn9_whitener_chk #(.HDR_BYTES(HDR_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_wht_en (in_wht_en),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/pn9_whitener_tb.sv
module pn9_whitener_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_wht_en = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [8:0] m_state = 9'h1F0;
    int         m_cnt   = 2;
    logic       m_en    = 1'b0;
    logic       m_first = 1'b0;

    always #5 clk = ~clk;

    pn9_whitener #(.HDR_BYTES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_wht_en (in_wht_en),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_mask(input logic [8:0] s, output logic [8:0] nxt);
        logic [7:0] m;
        logic [8:0] st;
        st = s;
        for (int i = 0; i < 8; i++) begin
            m[i] = st[0];
            st   = {st[0] ^ st[5], st[8:1]};
        end
        nxt = st;
        return m;
    endfunction

    // predicted output of a beat, plus the tag of the rule that sets it
    task automatic predict(input logic [7:0] d, input logic sof, output logic [7:0] exp,
                           output string tag, output logic [8:0] nxt);
        logic [7:0] m;
        nxt = m_state;
        if (sof || m_cnt < 2) begin
            exp = d; tag = "R2";
        end else if (m_en) begin
            m   = gen_mask(m_state, nxt);
            exp = d ^ m; tag = "R3";
        end else begin
            exp = d; tag = "R5";
        end
    endtask

    task automatic send(input logic [7:0] d, input logic sof, input logic eof,
                        input logic en, input int idles, input int stalls, input bit pre_sof);
        logic [7:0] exp;
        logic [8:0] nxt;
        string      tag;
        for (int i = 0; i < idles; i++) begin
            @(negedge clk);
            in_valid = 1'b0; out_ready = 1'b1;
            #1 check("R1 idle valid", out_valid, 0);
        end
        predict(d, sof, exp, tag, nxt);
        if (pre_sof) tag = "R8";
        for (int i = 0; i < stalls; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof; in_wht_en = en;
            out_ready = 1'b0;
            #1;
            check("R1 stall ready", in_ready, 0);
            check("R1 stall valid", out_valid, 1);
            check("R7 stall data", out_data, exp);
        end
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof; in_wht_en = en;
        out_ready = 1'b1;
        #1;
        if (!sof && m_cnt >= 2 && en != m_en) tag = "R6";
        if (stalls > 0 && tag == "R3") tag = "R7";
        check(tag, out_data, exp);
        check("R1 sof", out_sof, sof);
        check("R1 eof", out_eof, eof);
        check("R1 ready", in_ready, 1);
        if (!sof && m_cnt >= 2 && m_en && m_first)
            check("R4 first mask", out_data ^ d, 8'hF0);
        // model update for the acceptance at the next rising edge
        if (sof) begin
            m_state = 9'h1F0; m_cnt = 1; m_en = en; m_first = 1'b1;
        end else if (m_cnt < 2) begin
            m_cnt++;
        end else begin
            m_state = nxt; m_first = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; out_ready = 1'b1;
        #1;
        check("R8 reset valid", out_valid, 0);
        check("R1 reset ready", in_ready, 1);
        // R8: bytes before any start-of-frame pass unchanged
        for (int i = 0; i < 4; i++)
            send(8'(8'h5A + i * 37), 1'b0, 1'b0, 1'b1, 0, 0, 1'b1);
        // sweep of frames: lengths 1..25, enable patterns, stalls and gaps
        for (int f = 0; f < 60; f++) begin
            int  len;
            bit  en;
            len = 1 + (f % 25);
            en  = (f % 3) != 0;
            for (int b = 0; b < len; b++) begin
                logic [7:0] d;
                logic       en_b;
                int         st;
                int         id;
                d    = 8'($urandom);
                en_b = (b == 0) ? en : 1'($urandom);
                st   = (($urandom % 4) == 0) ? int'(1 + $urandom % 2) : 0;
                id   = (($urandom % 5) == 0) ? 1 : 0;
                send(d, b == 0, b == len - 1, en_b, id, st, 1'b0);
            end
        end
        // all-zero payload exposes the raw mask sequence (R3)
        send(8'h00, 1'b1, 1'b0, 1'b1, 0, 0, 1'b0);
        send(8'h00, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        for (int b = 0; b < 70; b++)
            send(8'h00, 1'b0, b == 69, 1'b0, 0, 0, 1'b0);
        // frame restart mid-frame: reseed (R4)
        send(8'h11, 1'b1, 1'b0, 1'b1, 0, 0, 1'b0);
        send(8'h22, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
        send(8'h33, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
        send(8'h44, 1'b1, 1'b0, 1'b1, 0, 0, 1'b0);
        send(8'h55, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
        send(8'h66, 1'b0, 1'b1, 1'b1, 0, 0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule